// File: doc/BRIEF.md
# Page-Mode DRAM Strobe Controller

This block sits between a synchronous request port and an asynchronous DRAM array that shares its address pins between row and column. Each request is accepted through a valid/ready handshake. The block turns it into a sequence of row strobes, column strobes, a write enable, an output enable and a multiplexed address. The row strobe is active low and there is one per bank.

After an access, the row stays open. A later request to the same bank and row is served with a column strobe alone. A request to any other row first raises the row strobe, waits out a precharge interval, and then opens the new row.

A free-running timer asks for a refresh once per programmed period. The controller serves the request ahead of the next normal access. It closes the open row if there is one, and then issues a column-first refresh. In that cycle the device steps through rows with its own counter, so no row address is driven. Every interval is a whole number of clock cycles set by a parameter.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, every row strobe, the column strobe, the write enable and the output enable are high, and `req_ready` is high.
- R2: For a request that finds no row open, the addressed bank's row strobe falls while `dram_addr` carries the row. The column strobe falls T_RCD cycles later while `dram_addr` carries the column. For a read, `rd_valid` is high in the cycle T_RCD+T_CAS clock edges after the accepting edge.
- R3: A request to the open bank and row produces no row strobe edge, only a column strobe. A read of this kind has a latency of T_CAS cycles.
- R4: A request to a different row while a row is open first raises all row strobes for T_RP cycles and then opens the new row. A read of this kind has a latency of T_RP+T_RCD+T_CAS cycles.
- R5: While the column strobe is low for a write, the write enable is low, `dram_dq_oe` is high and `dram_dq_out` equals the request data. While it is low for a read, the output enable is low. `rd_data` returns the value captured at the end of the column strobe pulse, and `rd_valid` is a one-cycle pulse.
- R6: Bank index value k selects row strobe bit k. During a normal access, at most that one row strobe is low.
- R7: With no traffic, column-first refreshes start exactly REF_PERIOD cycles apart.
- R8: In a refresh, the column strobe falls while all row strobes are high, with the write enable high. T_CSR cycles later, all row strobes fall together and stay low for T_RAS cycles. They then rise together with the column strobe. A refresh leaves no row open.
- R9: While a refresh is pending, `req_ready` is low. The refresh starts no later than the end of the access in progress plus one precharge, so steady page hits cannot starve it.
- R10: Every falling edge of a row strobe comes after at least T_RP cycles in which all row strobes were high.
- R11: Every falling edge of the column strobe comes after at least T_CP cycles in which it was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BW | Bank index |
| req_row | input | AW | Row address |
| req_col | input | AW | Column address |
| req_wdata | input | DW | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DW | Read data |
| dram_ras_n | output | BANKS | Row strobes, one per bank, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | AW | Multiplexed row/column address |
| dram_dq_out | output | DW | Data toward the array |
| dram_dq_oe | output | 1 | Enable for the data drivers |
| dram_dq_in | input | DW | Data from the array |

## Verification
Read latency is counted in clock edges from the accepting edge. It is T_RCD+T_CAS for a closed row, T_CAS for a hit, and T_RP+T_RCD+T_CAS for a miss. The bench predicts which case applies from its own record of the open row, and clears that record whenever it sees a refresh. It samples on falling edges and compares the cycle number at which `rd_valid` is first seen against the accept cycle plus the predicted latency. Strobe spacing is checked by counting falling-edge samples: precharge against T_RP, column-to-row lead against T_CSR, refresh pulse width against T_RAS, and refresh spacing against REF_PERIOD. That spacing must be exact when the bus is quiet, and must fall within a bound of one access plus one precharge when traffic is present.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_PRE, ST_ACT, ST_CAS, ST_CPRE, ST_RCAS, ST_RRAS
   } fpm_state_e;

   typedef enum logic [1:0] {
      NX_IDLE, NX_ACT, NX_REF
   } fpm_next_e;

   function automatic int fpm_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/fpm_ref_timer.sv
module fpm_ref_timer #(
   parameter int PERIOD = 1560
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pend
);
   localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

   logic [PW-1:0] tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick <= '0;
         pend <= 1'b0;
      end else begin
         if (tick == PW'(PERIOD - 1)) begin
            tick <= '0;
            pend <= 1'b1;
         end else begin
            tick <= tick + 1'b1;
            if (ack) pend <= 1'b0;
         end
      end
   end

   // R7: the sequencer only acknowledges a request that is outstanding
   p_ack_pending_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> pend);
endmodule

// File: rtl/fpm_page_tracker.sv
module fpm_page_tracker #(
   parameter int AW    = 11,
   parameter int BANKS = 2,
   parameter int BW    = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          open_set,
   input  logic          close_row,
   input  logic [BW-1:0] set_bank,
   input  logic [AW-1:0] set_row,
   input  logic [BW-1:0] q_bank,
   input  logic [AW-1:0] q_row,
   output logic          is_open,
   output logic [BW-1:0] open_bank,
   output logic          hit
);
   logic [AW-1:0] open_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open   <= 1'b0;
         open_bank <= '0;
         open_row  <= '0;
      end else if (open_set) begin
         is_open   <= 1'b1;
         open_bank <= set_bank;
         open_row  <= set_row;
      end else if (close_row) begin
         is_open   <= 1'b0;
      end
   end

   generate
      if (BANKS > 1) begin : g_multi
         assign hit = is_open && (open_bank == q_bank) && (open_row == q_row);
      end else begin : g_single
         assign hit = is_open && (open_row == q_row);
      end
   endgenerate

   // R4: a new row is only opened after the previous one has been closed
   p_open_from_closed_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      open_set |-> !is_open);
endmodule

// File: rtl/fpm_sequencer.sv
module fpm_sequencer
   import fpm_pkg::*;
#(
   parameter int AW    = 11,
   parameter int DW    = 32,
   parameter int BANKS = 2,
   parameter int BW    = 1,
   parameter int T_RP  = 3,
   parameter int T_RCD = 2,
   parameter int T_CAS = 2,
   parameter int T_CP  = 1,
   parameter int T_CSR = 1,
   parameter int T_RAS = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [BW-1:0]    req_bank,
   input  logic [AW-1:0]    req_row,
   input  logic [AW-1:0]    req_col,
   input  logic [DW-1:0]    req_wdata,
   output logic             req_ready,
   input  logic             ref_pend,
   output logic             ref_ack,
   input  logic             trk_open,
   input  logic             trk_hit,
   input  logic [BW-1:0]    trk_bank,
   output logic             open_set,
   output logic             close_row,
   output logic [BW-1:0]    set_bank,
   output logic [AW-1:0]    set_row,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic [BANKS-1:0] ras_n,
   output logic             cas_n,
   output logic             we_n,
   output logic             oe_n,
   output logic [AW-1:0]    addr,
   output logic [DW-1:0]    dq_out,
   output logic             dq_oe,
   input  logic [DW-1:0]    dq_in
);
   localparam int TMAX = fpm_max(fpm_max(fpm_max(T_RP, T_RCD), fpm_max(T_CAS, T_CP)),
                                 fpm_max(T_CSR, T_RAS));
   localparam int CW   = $clog2(TMAX + 1);

   fpm_state_e    state;
   fpm_next_e     nxt;
   logic [CW-1:0] cnt;
   logic          last;
   logic          accept;
   logic          lat_wr;
   logic [BW-1:0] lat_bank;
   logic [AW-1:0] lat_row;
   logic [AW-1:0] lat_col;
   logic [DW-1:0] lat_wdata;

   assign last      = (cnt == '0);
   assign req_ready = (state == ST_IDLE) && !ref_pend;
   assign accept    = req_ready && req_valid;

   assign ref_ack   = ((state == ST_IDLE) && ref_pend && !trk_open) ||
                      ((state == ST_PRE) && last && (nxt == NX_REF));
   assign open_set  = (accept && !trk_hit && !trk_open) ||
                      ((state == ST_PRE) && last && (nxt == NX_ACT));
   assign close_row = (state == ST_IDLE) && trk_open &&
                      (ref_pend || (req_valid && !trk_hit));
   assign set_bank  = (state == ST_IDLE) ? req_bank : lat_bank;
   assign set_row   = (state == ST_IDLE) ? req_row  : lat_row;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         nxt       <= NX_IDLE;
         cnt       <= '0;
         lat_wr    <= 1'b0;
         lat_bank  <= '0;
         lat_row   <= '0;
         lat_col   <= '0;
         lat_wdata <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
      end else begin
         rd_valid <= 1'b0;
         if (state == ST_IDLE) begin
            if (ref_pend) begin
               if (trk_open) begin
                  state <= ST_PRE;
                  nxt   <= NX_REF;
                  cnt   <= CW'(T_RP - 1);
               end else begin
                  state <= ST_RCAS;
                  cnt   <= CW'(T_CSR - 1);
               end
            end else if (req_valid) begin
               lat_wr    <= req_write;
               lat_bank  <= req_bank;
               lat_row   <= req_row;
               lat_col   <= req_col;
               lat_wdata <= req_wdata;
               if (trk_hit) begin
                  state <= ST_CAS;
                  cnt   <= CW'(T_CAS - 1);
               end else if (trk_open) begin
                  state <= ST_PRE;
                  nxt   <= NX_ACT;
                  cnt   <= CW'(T_RP - 1);
               end else begin
                  state <= ST_ACT;
                  cnt   <= CW'(T_RCD - 1);
               end
            end
         end else if (!last) begin
            cnt <= cnt - 1'b1;
         end else begin
            unique case (state)
               ST_PRE: begin
                  unique case (nxt)
                     NX_ACT: begin
                        state <= ST_ACT;
                        cnt   <= CW'(T_RCD - 1);
                     end
                     NX_REF: begin
                        state <= ST_RCAS;
                        cnt   <= CW'(T_CSR - 1);
                     end
                     default: state <= ST_IDLE;
                  endcase
               end
               ST_ACT: begin
                  state <= ST_CAS;
                  cnt   <= CW'(T_CAS - 1);
               end
               ST_CAS: begin
                  state <= ST_CPRE;
                  cnt   <= CW'(T_CP - 1);
                  if (!lat_wr) begin
                     rd_valid <= 1'b1;
                     rd_data  <= dq_in;
                  end
               end
               ST_CPRE: state <= ST_IDLE;
               ST_RCAS: begin
                  state <= ST_RRAS;
                  cnt   <= CW'(T_RAS - 1);
               end
               ST_RRAS: begin
                  state <= ST_PRE;
                  nxt   <= NX_IDLE;
                  cnt   <= CW'(T_RP - 1);
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   generate
      for (genvar b = 0; b < BANKS; b++) begin : g_ras
         assign ras_n[b] = ~((trk_open && (trk_bank == BW'(b))) || (state == ST_RRAS));
      end
   endgenerate

   assign cas_n  = ~((state == ST_CAS) || (state == ST_RCAS) || (state == ST_RRAS));
   assign we_n   = ~((state == ST_CAS) && lat_wr);
   assign oe_n   = ~((state == ST_CAS) && !lat_wr);
   assign dq_oe  = (state == ST_CAS) && lat_wr;
   assign dq_out = lat_wdata;
   assign addr   = (state == ST_ACT) ? lat_row : lat_col;

   p_ready_blocked_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      ref_pend |-> !req_ready);
   p_hit_keeps_row_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (accept && trk_hit) |=> $stable(ras_n));
   p_one_bank_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_RRAS) |-> $onehot0(~ras_n));
   p_refresh_no_write_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && (&ras_n)) |-> we_n);
   p_rd_pulse_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl #(
   parameter int AW         = 11,
   parameter int DW         = 32,
   parameter int BANKS      = 2,
   parameter int T_RP       = 3,
   parameter int T_RCD      = 2,
   parameter int T_CAS      = 2,
   parameter int T_CP       = 1,
   parameter int T_CSR      = 1,
   parameter int T_RAS      = 5,
   parameter int REF_PERIOD = 1560,
   localparam int BW        = (BANKS > 1) ? $clog2(BANKS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [BW-1:0]    req_bank,
   input  logic [AW-1:0]    req_row,
   input  logic [AW-1:0]    req_col,
   input  logic [DW-1:0]    req_wdata,
   output logic             rd_valid,
   output logic [DW-1:0]    rd_data,
   output logic [BANKS-1:0] dram_ras_n,
   output logic             dram_cas_n,
   output logic             dram_we_n,
   output logic             dram_oe_n,
   output logic [AW-1:0]    dram_addr,
   output logic [DW-1:0]    dram_dq_out,
   output logic             dram_dq_oe,
   input  logic [DW-1:0]    dram_dq_in
);
   localparam int WORST = 2 * T_RP + T_RCD + T_CAS + T_CP + T_CSR + T_RAS;

   generate
      if (T_RP < 1 || T_RCD < 1 || T_CAS < 1 || T_CP < 1 || T_CSR < 1 || T_RAS < 1) begin : g_bad_timing
         $error("fpm_dram_ctrl: every timing count must be at least one cycle");
      end
      if (REF_PERIOD <= WORST) begin : g_bad_period
         $error("fpm_dram_ctrl: refresh period too short for one access plus one refresh");
      end
      if (BANKS < 1 || AW < 1 || DW < 1) begin : g_bad_shape
         $error("fpm_dram_ctrl: bank count and bus widths must be positive");
      end
   endgenerate

   logic          ref_pend;
   logic          ref_ack;
   logic          trk_open;
   logic          trk_hit;
   logic [BW-1:0] trk_bank;
   logic          open_set;
   logic          close_row;
   logic [BW-1:0] set_bank;
   logic [AW-1:0] set_row;

   fpm_ref_timer #(.PERIOD(REF_PERIOD)) timer_i (
      .clk  (clk),
      .rst_n(rst_n),
      .ack  (ref_ack),
      .pend (ref_pend)
   );

   fpm_page_tracker #(.AW(AW), .BANKS(BANKS), .BW(BW)) tracker_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_set (open_set),
      .close_row(close_row),
      .set_bank (set_bank),
      .set_row  (set_row),
      .q_bank   (req_bank),
      .q_row    (req_row),
      .is_open  (trk_open),
      .open_bank(trk_bank),
      .hit      (trk_hit)
   );

   fpm_sequencer #(
      .AW(AW), .DW(DW), .BANKS(BANKS), .BW(BW),
      .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
      .T_CSR(T_CSR), .T_RAS(T_RAS)
   ) seq_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_write(req_write),
      .req_bank (req_bank),
      .req_row  (req_row),
      .req_col  (req_col),
      .req_wdata(req_wdata),
      .req_ready(req_ready),
      .ref_pend (ref_pend),
      .ref_ack  (ref_ack),
      .trk_open (trk_open),
      .trk_hit  (trk_hit),
      .trk_bank (trk_bank),
      .open_set (open_set),
      .close_row(close_row),
      .set_bank (set_bank),
      .set_row  (set_row),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .ras_n    (dram_ras_n),
      .cas_n    (dram_cas_n),
      .we_n     (dram_we_n),
      .oe_n     (dram_oe_n),
      .addr     (dram_addr),
      .dq_out   (dram_dq_out),
      .dq_oe    (dram_dq_oe),
      .dq_in    (dram_dq_in)
   );
endmodule

// File: tb/fpm_dram_ctrl_tb_top.sv
module fpm_dram_ctrl_tb_top;
   localparam int AW = 11, DW = 8, BANKS = 2;
   localparam int T_RP = 2, T_RCD = 2, T_CAS = 2, T_CP = 1, T_CSR = 1, T_RAS = 3;
   localparam int REF = 300;
   localparam int SLACK = 2 * T_RP + T_RCD + T_CAS + T_CP + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic req_bank = 1'b0;
   logic [AW-1:0] req_row = '0, req_col = '0;
   logic [DW-1:0] req_wdata = '0;
   logic req_ready, rd_valid;
   logic [DW-1:0] rd_data;
   logic [BANKS-1:0] dram_ras_n;
   logic dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
   logic [AW-1:0] dram_addr;
   logic [DW-1:0] dram_dq_out;
   logic [DW-1:0] dram_dq_in = '0;

   always #5 clk = ~clk;

   fpm_dram_ctrl #(
      .AW(AW), .DW(DW), .BANKS(BANKS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
      .T_CP(T_CP), .T_CSR(T_CSR), .T_RAS(T_RAS), .REF_PERIOD(REF)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
      .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
      .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
   );

   int total = 0, bad = 0;
   int cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int b, input int r, input int c);
      return DW'(b * 37 + r * 11 + c * 5 + 1);
   endfunction

   // bench view of the open row and of the request in flight
   bit bopen = 0;
   int bbank = 0, brow = 0;
   int cur_bank = 0, cur_row = 0, cur_col = 0;
   bit acc_since = 0;
   int ras_falls = 0;
   int exact_n = 0;

   // DRAM model and strobe monitor
   logic [DW-1:0] mem [int];
   logic [BANKS-1:0] prev_ras = '1;
   logic prev_cas = 1'b1;
   int hi_cnt = 1000, cas_hi = 1000;
   int cbr_cas_cyc = 0, cbr_ras_cyc = 0, last_cbr = 0;
   bit in_rr = 0, have_last = 0, last_quiet = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (|(prev_ras & ~dram_ras_n)) begin
            chk(hi_cnt >= T_RP, "R10 precharge before row strobe", hi_cnt, T_RP);
            if (!dram_cas_n) begin
               chk(dram_ras_n == '0, "R8 all banks fall together", int'(dram_ras_n), 0);
               chk(dram_we_n == 1'b1, "R8 write enable high", int'(dram_we_n), 1);
               chk(cyc - cbr_cas_cyc == T_CSR, "R8 column lead", cyc - cbr_cas_cyc, T_CSR);
               cbr_ras_cyc = cyc;
               in_rr = 1;
               bopen = 0;
            end else begin
               ras_falls++;
               chk(dram_ras_n == ~(2'b01 << cur_bank), "R6 bank select",
                   int'(dram_ras_n), int'(~(2'b01 << cur_bank)));
               chk(int'(dram_addr) == cur_row, "R2 row address", int'(dram_addr), cur_row);
            end
         end
         if (in_rr && (&dram_ras_n)) begin
            chk(cyc - cbr_ras_cyc == T_RAS, "R8 refresh pulse width", cyc - cbr_ras_cyc, T_RAS);
            chk(dram_cas_n == 1'b1, "R8 column strobe rises with row", int'(dram_cas_n), 1);
            in_rr = 0;
         end
         if (prev_cas && !dram_cas_n) begin
            chk(cas_hi >= T_CP, "R11 column precharge", cas_hi, T_CP);
            if (&dram_ras_n) begin
               cbr_cas_cyc = cyc;
               if (have_last) begin
                  if (!acc_since && last_quiet) begin
                     chk(cyc - last_cbr == REF, "R7 idle refresh spacing", cyc - last_cbr, REF);
                     exact_n++;
                  end else begin
                     chk((cyc - last_cbr <= REF + SLACK) && (cyc - last_cbr + SLACK >= REF),
                         "R9 refresh spacing under traffic", cyc - last_cbr, REF);
                  end
               end
               last_quiet = !acc_since;
               acc_since = 0;
               last_cbr = cyc;
               have_last = 1;
            end else begin
               chk(int'(dram_addr) == cur_col, "R2 column address", int'(dram_addr), cur_col);
               if (!dram_we_n) begin
                  chk(dram_dq_oe == 1'b1, "R5 data drive on write", int'(dram_dq_oe), 1);
                  chk(dram_dq_out == pat(cur_bank, cur_row, cur_col), "R5 write data",
                      int'(dram_dq_out), int'(pat(cur_bank, cur_row, cur_col)));
                  mem[(cur_bank << 22) | (cur_row << 11) | cur_col] = dram_dq_out;
               end else begin
                  chk(dram_oe_n == 1'b0, "R5 output enable on read", int'(dram_oe_n), 0);
                  if (mem.exists((cur_bank << 22) | (cur_row << 11) | cur_col))
                     dram_dq_in = mem[(cur_bank << 22) | (cur_row << 11) | cur_col];
                  else
                     dram_dq_in = '0;
               end
            end
         end
         hi_cnt = (&dram_ras_n) ? hi_cnt + 1 : 0;
         cas_hi = dram_cas_n ? cas_hi + 1 : 0;
         prev_ras = dram_ras_n;
         prev_cas = dram_cas_n;
      end
   end

   task automatic access(input bit wr, input int b, input int r, input int c);
      int acc, exp_lat, rf0, n;
      bit hit, miss;
      string tag;
      @(negedge clk);
      req_write = wr;
      req_bank  = b[0];
      req_row   = AW'(r);
      req_col   = AW'(c);
      req_wdata = pat(b, r, c);
      req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      hit  = bopen && bbank == b && brow == r;
      miss = bopen && !hit;
      exp_lat = hit ? T_CAS : (miss ? T_RP + T_RCD + T_CAS : T_RCD + T_CAS);
      tag = hit ? "R3 hit latency" : (miss ? "R4 miss latency" : "R2 closed latency");
      cur_bank = b; cur_row = r; cur_col = c;
      acc = cyc + 1;
      rf0 = ras_falls;
      @(negedge clk);
      req_valid = 1'b0;
      acc_since = 1;
      bopen = 1; bbank = b; brow = r;
      if (!wr) begin
         n = 0;
         while (!rd_valid && n < 60) begin
            @(negedge clk);
            n++;
         end
         chk(cyc - acc == exp_lat, tag, cyc - acc, exp_lat);
         chk(rd_data == pat(b, r, c), "R5 read data", int'(rd_data), int'(pat(b, r, c)));
         chk(ras_falls - rf0 == (hit ? 0 : 1), hit ? "R3 no row strobe on hit" : "R4 one row strobe",
             ras_falls - rf0, hit ? 0 : 1);
         @(negedge clk);
         chk(rd_valid == 1'b0, "R5 single-cycle valid", int'(rd_valid), 0);
      end
   endtask

   int rows [3] = '{0, 3, 2047};

   initial begin
      repeat (5) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dram_ras_n == '1, "R1 row strobes", int'(dram_ras_n), 3);
      chk(dram_cas_n == 1'b1, "R1 column strobe", int'(dram_cas_n), 1);
      chk(dram_we_n == 1'b1, "R1 write enable", int'(dram_we_n), 1);
      chk(dram_oe_n == 1'b1, "R1 output enable", int'(dram_oe_n), 1);
      chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);

      for (int b = 0; b < 2; b++)
         for (int ri = 0; ri < 3; ri++)
            for (int c = 0; c < 4; c++)
               access(1'b1, b, rows[ri], c);
      for (int b = 0; b < 2; b++)
         for (int ri = 0; ri < 3; ri++)
            for (int c = 0; c < 4; c++)
               access(1'b0, b, rows[ri], c);
      for (int c = 0; c < 4; c++)
         for (int ri = 0; ri < 3; ri++)
            for (int b = 0; b < 2; b++)
               access(1'b0, b, rows[ri], c);
      // steady page hits across several refresh periods
      for (int k = 0; k < 120; k++)
         access(1'b0, 1, 2047, k % 4);

      repeat (4 * REF) @(negedge clk);
      chk(exact_n >= 2, "R7 idle refreshes observed", exact_n, 2);
      access(1'b0, 0, 3, 2);
      access(1'b0, 0, 3, 1);

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule